// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single output line. Written bytes go into a four-entry queue. A serializer takes them out one at a time. Each frame has a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a stop period of one, one and a half or two bit times. The line rests high between frames. Bit timing comes from an external oversample strobe: one bit lasts 16 strobes, which also allows a half-bit stop period to be timed.

Software can choose between two interrupt policies. In batch mode the request is raised only when the queue is fully empty, so up to four bytes can be written per interrupt. In the other mode the request follows a room-available flag, which is high whenever the queue can accept another byte. A separate done flag reports that the wire itself has gone quiet, meaning the last stop period has finished. A queue that is merely empty does not raise it. A write that arrives while the queue is full is dropped and sets a sticky overflow flag, which a clear command removes.

Top module: `serial_tx_unit`

## Requirements
- R1: The queue holds four bytes. `tbe` is 1 while fewer than four bytes are queued and 0 when four are queued. Bytes are sent in the order they were written.
- R2: A frame begins with one low start bit. The data bits follow least significant bit first, and the line is high whenever no frame is in progress.
- R3: `char_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Unused upper bits of the written byte are not sent.
- R4: With `par_en`=1, one parity bit follows the data. For `par_even`=1 it equals the XOR of the sent data bits (even parity). For `par_even`=0 it is the inverse of that XOR (odd parity).
- R5: One bit time is 16 pulses of `os_tick`. `stop_sel` 01 gives a high stop period of 16 pulses, 10 gives 24 pulses and 11 gives 32 pulses.
- R6: With `stop_sel`=00, no frame starts. The line stays high and queued bytes wait.
- R7: With `batch_mode`=1, `tx_irq` is 1 only when the queue is empty. With `batch_mode`=0, `tx_irq` equals `tbe`.
- R8: `all_sent` is 1 after reset. It is 0 while a byte is queued or a frame is on the line. It becomes 1 in the cycle the final stop period ends.
- R9: A write while four bytes are queued is discarded and sets `wr_ovf`. `wr_ovf` stays set until `err_reset`. When an overflowing write and `err_reset` arrive in the same cycle, the flag stays set.
- R10: When another byte is queued as a stop period ends, the next start bit begins in the very next cycle, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| char_len | input | 2 | Data bits per frame (5 + value) |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop_sel | input | 2 | Stop period select; 00 halts the serializer |
| batch_mode | input | 1 | Interrupt policy select |
| err_reset | input | 1 | Clears the overflow flag |
| os_tick | input | 1 | Oversample strobe, 16 per bit |
| txd | output | 1 | Serial output line |
| tbe | output | 1 | Queue has room for a byte |
| tx_irq | output | 1 | Transmit interrupt request |
| all_sent | output | 1 | Queue empty and line idle |
| wr_ovf | output | 1 | Sticky dropped-write flag |

## Verification
Two events can fall in the same cycle. One is a write that overflows the full queue, which sets the overflow flag. The other is the clear command, which removes it. The bench holds the serializer halted with four bytes queued, then raises a fifth write and the clear command together. It expects the flag to read set afterwards, and to drop only after a later clear that comes alone. A second overlap also matters: a stop period can end in the same cycle as the next byte is loaded. Back-to-back frames are decoded, and the bench judges that the next start bit appears exactly one frame length after the previous one, while the done flag stays low.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_even;
        logic [1:0] stop;
    } tx_cfg_t;

    // Parity over the low 5+len bits of a byte.
    function automatic logic par_bit(input logic [CHAR_W-1:0] d,
                                     input logic [1:0] len,
                                     input logic even);
        logic [CHAR_W-1:0] m;
        m = d & (8'hFF >> (2'd3 - len));
        return even ? (^m) : ~(^m);
    endfunction

endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    p_full_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> full);

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
    import stx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  tx_cfg_t           cfg,
    input  logic              q_empty,
    input  logic [CHAR_W-1:0] q_data,
    output logic              pop,
    output logic              txd,
    output logic              busy
);
    localparam int TW = $clog2(2 * OSR) + 1;
    localparam logic [TW-1:0] LIM_ONE  = TW'(OSR);
    localparam logic [TW-1:0] LIM_HALF = TW'(OSR + OSR / 2);
    localparam logic [TW-1:0] LIM_TWO  = TW'(2 * OSR);

    tx_state_e         state;
    logic [TW-1:0]     tcnt, stop_lim, lim, sel_lim;
    logic [CHAR_W-1:0] shreg;
    logic [2:0]        bidx, nlast;
    logic              par_q, paren_q, bit_end, can_load;

    always_comb begin
        case (cfg.stop)
            2'b10:   sel_lim = LIM_HALF;
            2'b11:   sel_lim = LIM_TWO;
            default: sel_lim = LIM_ONE;
        endcase
    end

    assign lim      = (state == ST_STOP) ? stop_lim : LIM_ONE;
    assign bit_end  = os_tick && (tcnt == lim - 1'b1);
    assign can_load = !q_empty && (cfg.stop != 2'b00);
    assign pop      = can_load && ((state == ST_IDLE) || (state == ST_STOP && bit_end));
    assign busy     = (state != ST_IDLE);

    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            tcnt     <= '0;
            shreg    <= '1;
            bidx     <= '0;
            nlast    <= '0;
            par_q    <= 1'b0;
            paren_q  <= 1'b0;
            stop_lim <= LIM_ONE;
        end else if (pop) begin
            state    <= ST_START;
            tcnt     <= '0;
            shreg    <= q_data;
            bidx     <= '0;
            nlast    <= 3'd4 + {1'b0, cfg.len};
            par_q    <= par_bit(q_data, cfg.len, cfg.par_even);
            paren_q  <= cfg.par_en;
            stop_lim <= sel_lim;
        end else if (state != ST_IDLE && os_tick) begin
            if (bit_end) begin
                tcnt <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= {1'b1, shreg[CHAR_W-1:1]};
                        if (bidx == nlast) state <= paren_q ? ST_PAR : ST_STOP;
                        else               bidx  <= bidx + 1'b1;
                    end
                    ST_PAR:  state <= ST_STOP;
                    default: state <= ST_IDLE;
                endcase
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    p_start_after_pop_r2: assert property (@(posedge clk) disable iff (rst)
        pop |=> !txd);

    p_halted_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg.stop == 2'b00 && !busy) |=> !busy);

    p_no_load_empty_r1: assert property (@(posedge clk) disable iff (rst)
        q_empty |-> !pop);

endmodule

// File: rtl/stx_flags.sv
module stx_flags (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic q_full,
    input  logic q_empty,
    input  logic busy,
    input  logic batch_mode,
    input  logic err_reset,
    output logic tbe,
    output logic irq,
    output logic all_sent,
    output logic wr_ovf
);
    assign tbe      = !q_full;
    assign irq      = batch_mode ? q_empty : !q_full;
    assign all_sent = q_empty && !busy;

    always_ff @(posedge clk) begin
        if (rst)                   wr_ovf <= 1'b0;
        else if (wr_en && q_full)  wr_ovf <= 1'b1;
        else if (err_reset)        wr_ovf <= 1'b0;
    end

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_ovf && !err_reset) |=> wr_ovf);

    p_ovf_set_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && q_full) |=> wr_ovf);

    p_irq_room_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> tbe);

    p_sent_room_r8: assert property (@(posedge clk) disable iff (rst)
        all_sent |-> irq);

endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit
    import stx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OSR   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       par_even,
    input  logic [1:0] stop_sel,
    input  logic       batch_mode,
    input  logic       err_reset,
    input  logic       os_tick,
    output logic       txd,
    output logic       tbe,
    output logic       tx_irq,
    output logic       all_sent,
    output logic       wr_ovf
);
    tx_cfg_t           cfg;
    logic [CHAR_W-1:0] q_data;
    logic              q_full, q_empty, pop, busy;

    assign cfg = '{len: char_len, par_en: par_en, par_even: par_even, stop: stop_sel};

    stx_fifo #(.DW(CHAR_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (pop),
        .dout  (q_data),
        .full  (q_full),
        .empty (q_empty)
    );

    stx_shifter #(.OSR(OSR)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .os_tick (os_tick),
        .cfg     (cfg),
        .q_empty (q_empty),
        .q_data  (q_data),
        .pop     (pop),
        .txd     (txd),
        .busy    (busy)
    );

    stx_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .q_full     (q_full),
        .q_empty    (q_empty),
        .busy       (busy),
        .batch_mode (batch_mode),
        .err_reset  (err_reset),
        .tbe        (tbe),
        .irq        (tx_irq),
        .all_sent   (all_sent),
        .wr_ovf     (wr_ovf)
    );

endmodule

// File: tb/serial_tx_unit_tb_top.sv
`timescale 1ns/1ps
module serial_tx_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] char_len = '0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic [1:0] stop_sel = 2'b01;
    logic       batch_mode = 1'b0;
    logic       err_reset = 1'b0;
    logic       os_tick = 1'b1;
    logic       txd, tbe, tx_irq, all_sent, wr_ovf;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    serial_tx_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .char_len(char_len), .par_en(par_en), .par_even(par_even),
        .stop_sel(stop_sel), .batch_mode(batch_mode), .err_reset(err_reset),
        .os_tick(os_tick), .txd(txd), .tbe(tbe), .tx_irq(tx_irq),
        .all_sent(all_sent), .wr_ovf(wr_ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_start();
        int guard = 0;
        while (txd !== 1'b0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 2000) chk("R2 start never seen", 1, 0);
    endtask

    // Called at the first negedge with the start bit on the line.
    task automatic frame(input logic [7:0] d, input bit last);
        int n    = 5 + int'(char_len);
        int p    = par_en ? 1 : 0;
        int s    = (stop_sel == 2'b01) ? 16 : (stop_sel == 2'b10) ? 24 : 32;
        int base = 16 * (1 + n + p);
        int tend = base + s;
        logic [7:0] mask = 8'hFF >> (8 - n);
        logic [7:0] rx   = '0;
        logic       expp = par_even ? ^(d & mask) : ~^(d & mask);
        for (int t = 0; t <= tend; t++) begin
            if (t == 8) chk("R2 start bit low", int'(txd), 0);
            if (t >= 16 && t < 16 + 16 * n && ((t - 16) % 16) == 8)
                rx[(t - 16) / 16] = txd;
            if (p == 1 && t == 16 * (1 + n) + 8) chk("R4 parity bit", int'(txd), int'(expp));
            if (t == base + s / 2) chk("R5 stop level", int'(txd), 1);
            if (t == tend - 1) chk("R8 all_sent low before stop end", int'(all_sent), 0);
            if (t == tend) begin
                chk("R5 R8 all_sent at stop end", int'(all_sent), last ? 1 : 0);
                chk("R10 line at stop end", int'(txd), last ? 1 : 0);
            end
            if (t < tend) @(negedge clk);
        end
        chk("R3 data bits LSB first", int'(rx), int'(d & mask));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset line high", int'(txd), 1);
        chk("R1 reset tbe", int'(tbe), 1);
        chk("R7 reset irq", int'(tx_irq), 1);
        chk("R8 reset all_sent", int'(all_sent), 1);
        chk("R9 reset ovf", int'(wr_ovf), 0);

        // Sweep every character format, two frames back to back each.
        for (int len = 0; len < 4; len++)
            for (int pe = 0; pe < 2; pe++)
                for (int pv = 0; pv < 2; pv++)
                    for (int st = 1; st < 4; st++) begin
                        logic [7:0] d;
                        d        = 8'(len * 61 + pe * 37 + pv * 19 + st * 11 + 8'h5A);
                        char_len = 2'(len);
                        par_en   = pe[0];
                        par_even = pv[0];
                        stop_sel = 2'(st);
                        put(d);
                        put(~d);
                        wait_start();
                        frame(d, 1'b0);
                        frame(~d, 1'b1);
                    end

        // Halted serializer, fill, overflow, simultaneous clear.
        char_len = 2'b11; par_en = 1'b0; stop_sel = 2'b00; batch_mode = 1'b0;
        @(negedge clk);
        put(8'hA0); put(8'hA1); put(8'hA2);
        chk("R1 tbe with three queued", int'(tbe), 1);
        put(8'hA3);
        chk("R1 tbe with four queued", int'(tbe), 0);
        chk("R7 irq room policy full", int'(tx_irq), 0);
        batch_mode = 1'b1; #1;
        chk("R7 irq batch policy full", int'(tx_irq), 0);
        chk("R8 all_sent with queued bytes", int'(all_sent), 0);
        put(8'hEE);
        chk("R9 overflow set", int'(wr_ovf), 1);
        chk("R1 still full after drop", int'(tbe), 0);
        begin
            bit stayed_high = 1'b1;
            for (int i = 0; i < 100; i++) begin
                if (txd !== 1'b1) stayed_high = 1'b0;
                @(negedge clk);
            end
            chk("R6 halted line stays high", int'(stayed_high), 1);
        end
        wr_en = 1'b1; wr_data = 8'hEF; err_reset = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; err_reset = 1'b0;
        chk("R9 set wins over clear", int'(wr_ovf), 1);
        err_reset = 1'b1;
        @(negedge clk);
        err_reset = 1'b0;
        chk("R9 cleared by err_reset", int'(wr_ovf), 0);

        // Release: four queued bytes drain back to back.
        stop_sel = 2'b01;
        wait_start();
        chk("R1 room after first load", int'(tbe), 1);
        chk("R7 batch irq waits for empty", int'(tx_irq), 0);
        batch_mode = 1'b0; #1;
        chk("R7 room policy irq", int'(tx_irq), 1);
        batch_mode = 1'b1; #1;
        frame(8'hA0, 1'b0);
        frame(8'hA1, 1'b0);
        frame(8'hA2, 1'b0);
        chk("R7 batch irq when empty", int'(tx_irq), 1);
        frame(8'hA3, 1'b1);
        begin
            bit quiet = 1'b1;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) quiet = 1'b0;
            end
            chk("R9 dropped bytes never sent", int'(quiet), 1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule